// File: doc/BRIEF.md
# Edge-Latched Interrupt Flag Controller

This block keeps the current level of five interrupt request lines and a five-bit pending register. Each line update carries a new level and a mask. Lines inside the mask take the new level. Lines outside the mask keep the level they already hold. A line inside the mask that goes from 0 to 1 sets its pending bit. A line that is already high, a falling line and a line outside the mask set nothing.

Software reaches the pending bits and a five-bit enable register through a small register port. Writes take effect at the next clock. Reads are combinational and return the current stored value.

The block also holds a halt latch. The processor sets this latch when it stops. The latch is released by a one-cycle wake pulse. Wake fires only when three things are true in the same update: a pending bit becomes newly set, that bit is enabled, and the master enable input is high. Vectoring, priority and acknowledge are left to the processor side.

Top module: `ifc_ctrl`

## Requirements
- R1: After reset, every stored line level, pending bit and enable bit is 0, and wake and halted are 0. A read of the pending register then returns 0xE0 and a read of the enable register returns 0x00.
- R2: When upd_valid is 1, each line whose upd_mask bit is 1 takes its upd_level bit at the next clock, including a level of 0. Lines whose mask bit is 0 keep their level. When upd_valid is 0, no line changes.
- R3: A line whose mask bit is 1, whose new level is 1 and whose stored level is 0 sets its pending bit at the next clock.
- R4: A line that is already high, a line that falls, a line outside the mask, and a cycle with no update all leave the pending bits unchanged, unless software writes them.
- R5: A pulse on one line (raise, then lower, in two updates) sets its pending bit once and leaves the line at 0.
- R6: Writing with reg_sel=0 loads reg_wdata[4:0] into the pending bits, and writing with reg_sel=1 loads reg_wdata[4:0] into the enable bits. A rising edge in the same cycle as a pending write still sets its bit.
- R7: With reg_sel=0, reg_rdata is {3'b111, pending[4:0]}. With reg_sel=1, it is {3'b000, enable[4:0]}.
- R8: wake is 1 for exactly the one cycle after an update in which some bit rose, was not already pending, is enabled, and master_en was 1. In every other cycle wake is 0.
- R9: halt_req sets halted at the next clock. A wake clears halted in the cycle it appears, and this clear wins over a halt_req in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Apply a line update this cycle |
| upd_level | input | 5 | New levels for the lines in the mask |
| upd_mask | input | 5 | Selects which lines this update touches |
| master_en | input | 1 | Master enable for the wake path |
| halt_req | input | 1 | Sets the halt latch |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects pending, 1 selects enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| line_state | output | 5 | Stored line levels |
| wake | output | 1 | One-cycle halt release pulse |
| halted | output | 1 | Halt latch state |

## Verification
Two pairs of events can land in the same cycle, and the bench drives each pair on purpose. The first pair is a software write of 0 to a pending bit and a rising edge on that same line. The expected result is that the bit stays set. The second pair is a halt request and a wake that fire together. The expected result is that halted reads 0. A reference model in the bench covers both orderings, along with long randomized stretches in which writes and updates overlap freely. The model is compared with the design after every clock.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic {
        SEL_PEND   = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/ifc_line_edge.sv
module ifc_line_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_valid,
    input  logic [N-1:0] upd_level,
    input  logic [N-1:0] upd_mask,
    output logic [N-1:0] lines_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] lines;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] lvl_in;

    always_comb begin
        st_d   = st_q;
        lvl_in = upd_level & upd_mask;
        rise_o = '0;
        if (upd_valid) begin
            rise_o      = lvl_in & ~st_q.lines;
            st_d.lines  = (st_q.lines & ~upd_mask) | lvl_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lines_o = st_q.lines;
endmodule

// File: rtl/ifc_flag_bank.sv
module ifc_flag_bank #(
    parameter int N  = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rise_i,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [N-1:0]  pend_o,
    output logic [N-1:0]  enable_o,
    output logic [N-1:0]  newly_o,
    output logic [DW-1:0] rdata_o
);
    import ifc_pkg::*;
    localparam int PAD = DW - N;

    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] en;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] pend_base;

    always_comb begin
        st_d      = st_q;
        pend_base = st_q.pend;
        if (reg_wr && reg_sel_e'(reg_sel) == SEL_PEND)
            pend_base = reg_wdata[N-1:0];
        if (reg_wr && reg_sel_e'(reg_sel) == SEL_ENABLE)
            st_d.en = reg_wdata[N-1:0];
        st_d.pend = pend_base | rise_i;
        newly_o   = rise_i & ~st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (PAD > 0) begin : g_pad
            always_comb begin
                if (reg_sel_e'(reg_sel) == SEL_PEND)
                    rdata_o = {{PAD{1'b1}}, st_q.pend};
                else
                    rdata_o = {{PAD{1'b0}}, st_q.en};
            end
        end else begin : g_nopad
            always_comb begin
                if (reg_sel_e'(reg_sel) == SEL_PEND) rdata_o = st_q.pend[DW-1:0];
                else                                  rdata_o = st_q.en[DW-1:0];
            end
        end
    endgenerate

    assign pend_o   = st_q.pend;
    assign enable_o = st_q.en;
endmodule

// File: rtl/ifc_wake_ctl.sv
module ifc_wake_ctl #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] newly_i,
    input  logic [N-1:0] enable_i,
    input  logic         master_en,
    input  logic         halt_req,
    output logic         wake_o,
    output logic         halted_o
);
    typedef struct packed {
        logic wake;
        logic halted;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = master_en && (|(newly_i & enable_i));
        if (st_d.wake)     st_d.halted = 1'b0;
        else if (halt_req) st_d.halted = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_o   = st_q.wake;
    assign halted_o = st_q.halted;
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl #(
    parameter int N  = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_valid,
    input  logic [N-1:0]  upd_level,
    input  logic [N-1:0]  upd_mask,
    input  logic          master_en,
    input  logic          halt_req,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [N-1:0]  line_state,
    output logic          wake,
    output logic          halted
);
    logic [N-1:0] rise_w, pend_w, enable_w, newly_w;

    ifc_line_edge #(.N(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
        .upd_level(upd_level), .upd_mask(upd_mask),
        .lines_o(line_state), .rise_o(rise_w)
    );

    ifc_flag_bank #(.N(N), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .pend_o(pend_w), .enable_o(enable_w), .newly_o(newly_w),
        .rdata_o(reg_rdata)
    );

    ifc_wake_ctl #(.N(N)) u_wake (
        .clk(clk), .rst_n(rst_n), .newly_i(newly_w), .enable_i(enable_w),
        .master_en(master_en), .halt_req(halt_req),
        .wake_o(wake), .halted_o(halted)
    );
endmodule

module ifc_ctrl_chk #(
    parameter int N  = 5,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          upd_valid,
    input logic [N-1:0]  upd_level,
    input logic [N-1:0]  upd_mask,
    input logic          master_en,
    input logic          reg_wr,
    input logic          reg_sel,
    input logic [DW-1:0] reg_rdata,
    input logic [N-1:0]  line_state,
    input logic          wake,
    input logic          halted,
    input logic [N-1:0]  pend
);
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(line_state)); // R2
    AST_LINE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (((line_state ^ $past(line_state)) & ~$past(upd_mask)) == '0)); // R2
    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ((pend & $past(upd_level & upd_mask & ~line_state))
                       == $past(upd_level & upd_mask & ~line_state))); // R3
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && !reg_wr) |=> $stable(pend)); // R4
    AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(master_en) && $past(upd_valid))); // R8
    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> !halted); // R9
    AST_READ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (&reg_rdata[DW-1:N])); // R7
endmodule

bind ifc_ctrl ifc_ctrl_chk #(.N(N), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_level(upd_level),
    .upd_mask(upd_mask), .master_en(master_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .line_state(line_state),
    .wake(wake), .halted(halted), .pend(pend_w)
);

// File: tb/ifc_ctrl_bench.sv
module ifc_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_valid = 1'b0;
    logic [4:0] upd_level = '0, upd_mask = '0;
    logic       master_en = 1'b0, halt_req = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] line_state;
    logic       wake, halted;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_lines = 0, m_pend = 0, m_en = 0, m_wake = 0, m_halted = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifc_ctrl u_ifc_ctrl (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_level(upd_level),
        .upd_mask(upd_mask), .master_en(master_en), .halt_req(halt_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .line_state(line_state), .wake(wake), .halted(halted)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cmp_all(input string tag);
        int exp_rd;
        exp_rd = reg_sel ? m_en : (32'hE0 | m_pend);
        chk({tag, " rdata"}, int'(reg_rdata), exp_rd);
        chk({tag, " lines"}, int'(line_state), m_lines);
        chk({tag, " wake"}, int'(wake), m_wake);
        chk({tag, " halted"}, int'(halted), m_halted);
    endtask

    task automatic step(input bit v, input int lv, input int mk, input bit me,
                        input bit hr, input bit wr, input bit sel, input int wd,
                        input string tag);
        int rise, fresh, nw;
        upd_valid = v; upd_level = lv[4:0]; upd_mask = mk[4:0];
        master_en = me; halt_req = hr; reg_wr = wr; reg_sel = sel; reg_wdata = wd[7:0];
        @(posedge clk);
        rise  = v ? (lv & mk & ~m_lines & 31) : 0;
        fresh = rise & ~m_pend;
        nw    = (me && ((fresh & m_en) != 0)) ? 1 : 0;
        if (v) m_lines = (m_lines & ~mk) | (lv & mk & 31);
        m_pend = ((wr && !sel) ? (wd & 31) : m_pend) | rise;
        if (wr && sel) m_en = wd & 31;
        m_wake = nw;
        if (nw) m_halted = 0;
        else if (hr) m_halted = 1;
        #1;
        cmp_all(tag);
    endtask

    task automatic idle(input bit sel, input string tag);
        step(0, 0, 0, 1, 0, 0, sel, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lfsr;
        repeat (3) @(posedge clk);
        #1;
        reg_sel = 0; #1; chk("R1 pend read", int'(reg_rdata), 32'hE0);
        reg_sel = 1; #1; chk("R1 enable read", int'(reg_rdata), 0);
        chk("R1 lines", int'(line_state), 0);
        chk("R1 wake", int'(wake), 0);
        chk("R1 halted", int'(halted), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        step(0, 0, 0, 1, 0, 1, 1, 32'hFF, "R6 enable write");
        idle(1, "R7 enable read");
        chk("R7 enable value", int'(reg_rdata), 32'h1F);
        step(0, 0, 0, 1, 1, 0, 0, 0, "R9 halt set");
        chk("R9 halted", int'(halted), 1);
        step(1, 32'h01, 32'h01, 1, 0, 0, 0, 0, "R3 edge line0");
        chk("R3 flag0", int'(reg_rdata), 32'hE1);
        chk("R8 wake pulse", int'(wake), 1);
        chk("R9 wake clears", int'(halted), 0);
        idle(0, "R8 wake one cycle");
        chk("R8 wake low", int'(wake), 0);
        step(1, 32'h01, 32'h01, 1, 0, 1, 0, 0, "R4 high stays no edge");
        chk("R4 no reflag", int'(reg_rdata), 32'hE0);
        step(1, 32'h04, 32'h04, 1, 0, 0, 0, 0, "R2 raise line2");
        step(1, 32'h00, 32'h01, 1, 0, 1, 0, 0, "R2 masked low");
        chk("R2 line0 low, line2 kept", int'(line_state), 32'h04);
        step(1, 32'h1F, 32'h00, 1, 0, 0, 0, 0, "R4 empty mask");
        chk("R4 nothing changes", int'(reg_rdata), 32'hE0);
        step(1, 32'h08, 32'h08, 1, 0, 0, 0, 0, "R5 pulse up");
        step(1, 32'h00, 32'h08, 1, 0, 0, 0, 0, "R5 pulse down");
        chk("R5 flag3 once", int'(reg_rdata), 32'hE8);
        chk("R5 line3 low", int'(line_state), 32'h04);
        step(1, 32'h02, 32'h02, 1, 0, 1, 0, 0, "R6 write vs edge");
        chk("R6 edge wins", int'(reg_rdata), 32'hE2);
        step(1, 32'h00, 32'h02, 1, 1, 0, 0, 0, "R8 drop line1 halt");
        step(1, 32'h02, 32'h02, 1, 0, 0, 0, 0, "R8 already pending");
        chk("R8 no wake when pending", int'(wake), 0);
        chk("R9 still halted", int'(halted), 1);
        step(1, 32'h10, 32'h10, 0, 0, 0, 0, 0, "R8 master off");
        chk("R8 no wake master off", int'(wake), 0);
        step(0, 0, 0, 1, 0, 1, 0, 0, "R6 clear");
        step(1, 32'h00, 32'h1F, 1, 0, 0, 0, 0, "R2 all low");
        step(1, 32'h01, 32'h01, 1, 1, 0, 0, 0, "R9 wake vs halt");
        chk("R9 wake wins", int'(halted), 0);
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >> 16) ^ (lfsr >> 13)) & 1);
            lfsr = lfsr & 32'h1FFFF;
            step(lfsr[0], lfsr >> 3, lfsr >> 8, lfsr[1] | lfsr[2], lfsr[13] & lfsr[14],
                 lfsr[15] & lfsr[2], lfsr[16], lfsr >> 5, "R3 R8 random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule